// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Controller

An eight-pad general purpose I/O peripheral behind a small synchronous register bus. The four low pads are driven outputs, the four high pads are sampled inputs. Software writes the output levels, reads back the actual pad levels, and chooses for every input pad whether a rising edge, a falling edge, both, or nothing raises a shared level interrupt.

Every input passes through a two-flop synchronizer and an edge detector. Rising and falling edges are latched in two separate hidden flag banks. A 2-bit trigger code per input decides which bank shows through in the status register and drives the interrupt. Clearing a status bit always wipes both hidden flags of that input, so a trigger change after a clear never exposes a stale edge.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, pad_out is 0, irq_o is 0, and the trigger register (offset 3) and the status register (offset 4) read 0.
- R2: The direction register at offset 0 always reads 0x0F: bit set means output (pads 0..3), bit clear means input (pads 4..7). Writes to it have no effect.
- R3: A write to offset 1 drives pad_out with write data bits 3:0 from the next clock edge on; bits 7:4 are ignored.
- R4: A read of offset 1 returns the synchronized levels of all eight pads (bit n = pad n), two clock edges after the pad changes, never the last written output value.
- R5: The trigger register at offset 3 is read/write; the field of input k (pad 4+k) is bits 2k+1:2k, code 0 = off, 1 = falling, 2 = rising, 3 = both.
- R6: A rising edge on pad 4+k sets a hidden rise flag; status bit k (offset 4) shows it when the code of input k is 2 or 3.
- R7: A falling edge on pad 4+k sets a hidden fall flag; status bit k shows it when the code of input k is 1 or 3.
- R8: Flags latch even while the code is 0 and stay hidden; a later code change makes them visible without a new edge.
- R9: Writing offset 4 clears both hidden flags of each input whose written bit is 1, whatever its code; inputs written with 0 keep their flags.
- R10: An edge detected in the same cycle as a status clear of that input wins: the flag stays set.
- R11: irq_o is a register holding the OR of the visible status bits, one clock edge after them; with all codes 0 it is low.
- R12: Offsets 2, 5, 6 and 7 read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Levels of all eight pads |
| pad_out | output | 4 | Output levels for pads 0..3 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: four outputs, four inputs, an 8-bit data bus and a two-stage synchronizer. With only four inputs, a single trigger byte covers every code on every input at once, so the vector table can mix falling, rising, both and off across pins in one step. The two-stage depth gives a short, fixed latency from pad change to flag, which lets the bench place a status clear exactly in the cycle an edge is detected.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Register byte offsets; software depends on these positions.
  localparam int unsigned OFS_DIR  = 0;
  localparam int unsigned OFS_DATA = 1;
  localparam int unsigned OFS_TRIG = 3;
  localparam int unsigned OFS_STAT = 4;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_ANY  = 2'd3
  } trig_e;

  // Visible status for one input: bit 1 of the code selects the rise
  // flag, bit 0 selects the fall flag.
  function automatic logic trig_visible(input logic [1:0] code,
                                        input logic rise_flag,
                                        input logic fall_flag);
    return (code[1] & rise_flag) | (code[0] & fall_flag);
  endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise_ev,
  output logic [W-1:0] fall_ev
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise_ev = lvl & ~prev_q;
  assign fall_ev = ~lvl & prev_q;

endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags
  import gpio_edge_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   rise_ev,
  input  logic [W-1:0]   fall_ev,
  input  logic [W-1:0]   clr,
  input  logic [2*W-1:0] trig,
  output logic [W-1:0]   rise_q,
  output logic [W-1:0]   fall_q,
  output logic [W-1:0]   vis
);

  for (genvar k = 0; k < W; k++) begin : g_pin
    logic r_q;
    logic f_q;

    // A new edge overrides a clear in the same cycle.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= 1'b0;
        f_q <= 1'b0;
      end else begin
        r_q <= rise_ev[k] | (r_q & ~clr[k]);
        f_q <= fall_ev[k] | (f_q & ~clr[k]);
      end
    end

    assign rise_q[k] = r_q;
    assign fall_q[k] = f_q;
    assign vis[k]    = trig_visible(trig[2*k+1 -: 2], r_q, f_q);
  end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int NUM_IN      = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_OUT+NUM_IN-1:0] pad_in,
  output logic [NUM_OUT-1:0]        pad_out,
  output logic                      irq_o
);

  localparam int NUM_PIN = NUM_OUT + NUM_IN;
  localparam int TRIG_W  = 2 * NUM_IN;
  localparam logic [DATA_W-1:0] DIR_WORD = DATA_W'((1 << NUM_OUT) - 1);

  // Named internal events, brought out for the checker.
  logic [NUM_PIN-1:0] pad_sync;
  logic [NUM_IN-1:0]  rise_ev;
  logic [NUM_IN-1:0]  fall_ev;
  logic [NUM_IN-1:0]  rise_q;
  logic [NUM_IN-1:0]  fall_q;
  logic [NUM_IN-1:0]  clr_mask;
  logic [NUM_IN-1:0]  status_vis;
  logic [TRIG_W-1:0]  trig_q;
  logic [NUM_OUT-1:0] out_q;
  logic               irq_q;

  logic wr_data;
  logic wr_trig;
  logic wr_stat;

  assign wr_data = bus_we && (bus_addr == ADDR_W'(OFS_DATA));
  assign wr_trig = bus_we && (bus_addr == ADDR_W'(OFS_TRIG));
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFS_STAT));

  assign clr_mask = wr_stat ? bus_wdata[NUM_IN-1:0] : '0;

  gpio_edge_sync #(.W(NUM_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  gpio_edge_detect #(.W(NUM_IN)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (pad_sync[NUM_PIN-1:NUM_OUT]),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  gpio_edge_flags #(.W(NUM_IN)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .clr     (clr_mask),
    .trig    (trig_q),
    .rise_q  (rise_q),
    .fall_q  (fall_q),
    .vis     (status_vis)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      trig_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_data) out_q  <= bus_wdata[NUM_OUT-1:0];
      if (wr_trig) trig_q <= bus_wdata[TRIG_W-1:0];
      irq_q <= |status_vis;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_DIR):  bus_rdata = DIR_WORD;
      ADDR_W'(OFS_DATA): bus_rdata = DATA_W'(pad_sync);
      ADDR_W'(OFS_TRIG): bus_rdata = DATA_W'(trig_q);
      ADDR_W'(OFS_STAT): bus_rdata = DATA_W'(status_vis);
      default:           bus_rdata = '0;
    endcase
  end

  assign pad_out = out_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NUM_OUT = 4,
  parameter int NUM_IN  = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NUM_OUT-1:0]    pad_out,
  input logic                  irq_o,
  input logic [2*NUM_IN-1:0]   trig_q,
  input logic [NUM_IN-1:0]     rise_ev,
  input logic [NUM_IN-1:0]     fall_ev,
  input logic [NUM_IN-1:0]     rise_q,
  input logic [NUM_IN-1:0]     fall_q,
  input logic [NUM_IN-1:0]     clr_mask,
  input logic [NUM_IN-1:0]     status_vis
);

  localparam logic [DATA_W-1:0] DIR_EXP = DATA_W'((1 << NUM_OUT) - 1);

  logic data_wr;
  assign data_wr = bus_we && (bus_addr == ADDR_W'(1));

  // R2: direction register is fixed
  a_r2_dir_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata == DIR_EXP));

  // R3: output register takes the written low bits
  a_r3_out_load: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (pad_out == $past(bus_wdata[NUM_OUT-1:0])));

  // R3: output holds without a data write
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(pad_out));

  // R9: a clear without a coincident edge empties both flags
  a_r9_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=>
      (((rise_q | fall_q) & $past(clr_mask & ~rise_ev & ~fall_ev)) == '0));

  // R10: a detected edge always lands in its flag
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_ev | fall_ev) != '0) |=>
      (((rise_q & $past(rise_ev)) == $past(rise_ev)) &&
       ((fall_q & $past(fall_ev)) == $past(fall_ev))));

  // R11: all codes off means nothing visible
  a_r11_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == '0) |-> (status_vis == '0));

  // R11: interrupt is the registered OR of visible status
  a_r11_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|status_vis)));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .NUM_OUT (NUM_OUT),
  .NUM_IN  (NUM_IN),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pad_out    (pad_out),
  .irq_o      (irq_o),
  .trig_q     (trig_q),
  .rise_ev    (rise_ev),
  .fall_ev    (fall_ev),
  .rise_q     (rise_q),
  .fall_q     (fall_q),
  .clr_mask   (clr_mask),
  .status_vis (status_vis)
);

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_DIR = 3'd0, A_DATA = 3'd1, A_TRIG = 3'd3, A_STAT = 3'd4;

  // {trigger byte, input nibble before, input nibble after, expected status}
  localparam int NVEC = 8;
  localparam logic [19:0] VEC [NVEC] = '{
    {8'h00, 4'h0, 4'hF, 4'h0},
    {8'hAA, 4'h0, 4'hF, 4'hF},
    {8'h55, 4'h0, 4'hF, 4'h0},
    {8'h55, 4'hF, 4'h0, 4'hF},
    {8'hAA, 4'hF, 4'h0, 4'h0},
    {8'hFF, 4'h5, 4'hA, 4'hF},
    {8'h09, 4'h0, 4'h3, 4'h2},
    {8'h84, 4'h2, 4'h8, 4'hA}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [3:0] pad_out;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .irq_o     (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = 8'h06;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1: reset state
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq", irq_o, 0);
    rd(A_TRIG, rv); chk("R1 trig", rv, 0);
    rd(A_STAT, rv); chk("R1 status", rv, 0);

    // Vector table: R6, R7, R11
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] tb_trig;
      logic [3:0] nb, na, ex;
      {tb_trig, nb, na, ex} = VEC[i];
      wr(A_TRIG, 8'h00);
      pad_in[7:4] = nb;
      wait_cyc(4);
      wr(A_STAT, 8'h0F);
      wr(A_TRIG, tb_trig);
      pad_in[7:4] = na;
      wait_cyc(5);
      rd(A_STAT, rv); chk("R6 R7 status vector", {24'd0, rv}, {28'd0, ex});
      chk("R11 irq vector", irq_o, |ex);
    end

    // R5: trigger register read/write
    wr(A_TRIG, 8'hC6);
    rd(A_TRIG, rv); chk("R5 trig readback", rv, 8'hC6);

    // R2: direction fixed, writes ignored
    wr(A_DIR, 8'h00);
    rd(A_DIR, rv); chk("R2 dir", rv, 8'h0F);

    // R3: output write, upper bits ignored
    wr(A_DATA, 8'h59);
    chk("R3 pad_out", pad_out, 4'h9);

    // R4: data read returns pad levels (low nibble 6, not written 9)
    rd(A_DATA, rv); chk("R4 data levels", rv, 8'h86);
    pad_in[7:4] = 4'h3;
    wait_cyc(1);
    rd(A_DATA, rv); chk("R4 after one edge", rv, 8'h86);
    wait_cyc(1);
    rd(A_DATA, rv); chk("R4 after two edges", rv, 8'h36);

    // R12: unmapped offsets
    wr(3'd2, 8'hFF);
    wr(3'd5, 8'hFF);
    rd(3'd2, rv); chk("R12 ofs2", rv, 0);
    rd(3'd5, rv); chk("R12 ofs5", rv, 0);
    rd(3'd6, rv); chk("R12 ofs6", rv, 0);
    rd(3'd7, rv); chk("R12 ofs7", rv, 0);
    rd(A_TRIG, rv); chk("R12 trig unchanged", rv, 8'hC6);
    chk("R12 pad_out unchanged", pad_out, 4'h9);

    // R8: hidden flag revealed by code change; R11 latency
    wr(A_TRIG, 8'h00);
    pad_in[7:4] = 4'h0;
    wait_cyc(4);
    wr(A_STAT, 8'h0F);
    pad_in[5] = 1'b1;
    wait_cyc(4);
    rd(A_STAT, rv); chk("R8 hidden", rv, 0);
    chk("R11 irq off", irq_o, 0);
    wr(A_TRIG, 8'h08);
    rd(A_STAT, rv); chk("R8 revealed", rv, 8'h02);
    chk("R11 irq not yet", irq_o, 0);
    wait_cyc(1);
    chk("R11 irq one edge later", irq_o, 1);

    // R9: partial write-one-to-clear
    wr(A_TRIG, 8'h28);
    pad_in[6] = 1'b1;
    wait_cyc(4);
    rd(A_STAT, rv); chk("R9 two pending", rv, 8'h06);
    wr(A_STAT, 8'h02);
    rd(A_STAT, rv); chk("R9 partial clear", rv, 8'h04);

    // R9: clear with code off wipes both hidden flags
    wr(A_TRIG, 8'h00);
    pad_in[6] = 1'b0;
    wait_cyc(4);
    wr(A_STAT, 8'h0F);
    wr(A_TRIG, 8'hFF);
    rd(A_STAT, rv); chk("R9 clear regardless of code", rv, 0);

    // R10: edge in the same cycle as a clear
    wr(A_TRIG, 8'h00);
    pad_in[7:4] = 4'h0;
    wait_cyc(4);
    wr(A_STAT, 8'h0F);
    wr(A_TRIG, 8'h02);
    @(negedge clk);
    pad_in[4] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr = A_STAT; bus_wdata = 8'h01; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    wait_cyc(1);
    rd(A_STAT, rv); chk("R10 edge beats clear", rv, 8'h01);
    wr(A_STAT, 8'h01);
    rd(A_STAT, rv); chk("R9 plain clear", rv, 0);
    wait_cyc(1);
    chk("R11 irq drops", irq_o, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule